// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block listens passively to the data bus of a NAND flash port and folds every data byte that moves to or from the selected bank into a Hamming-style parity code. Software picks a block length between 256 and 8192 bytes and raises the enable input. After the last byte of the block the code is frozen and flagged valid, so software can read it. Software then compares it with a stored code to correct one bit or detect two flipped bits. Dropping the enable clears the code, and raising it again starts a fresh block.

Only true data transfers count. A transfer counts on a rising edge of the read or write strobe while the bank chip-enable is low and the data-phase qualifier is high. Command and address cycles, and traffic to other banks, leave the code untouched. All bus inputs are asynchronous to the system clock and are resynchronised before edge detection. The bus width is a parameter. With a 16-bit bus each strobe adds its low byte and then its high byte.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, eccCode is all zeros and eccValid is low.
- R2: Bits [5:0] of eccCode hold the row parities. Bit 2r+1 is the XOR of all data bits whose bit position (0..7) has bit r set. Bit 2r is the XOR of the data bits whose position has bit r clear, for r = 0, 1, 2.
- R3: Bit 6+2k of eccCode is the XOR of every byte whose index within the block has bit k clear. Bit 7+2k covers the bytes whose index has bit k set. The block length is 256 << blockSize for blockSize values 0..5.
- R4: One byte is taken per rising edge of nandWeN or nandReN while nandCeN is low and dataPhase is high. A strobe held low for several cycles counts once.
- R5: A strobe edge while nandCeN is high, or while dataPhase is low, changes neither the code nor the byte count.
- R6: When the byte count reaches the block length, eccValid goes high. While eccEnable stays high, eccValid stays high, eccCode holds its value, and further strobes are ignored.
- R7: With eccEnable low, eccCode reads zero, eccValid is low and strobes are ignored. Raising eccEnable starts a new block from byte index zero.
- R8: Column parity bits for index bits at or above log2 of the block length read zero.
- R9: eccValid stays low while fewer than the block length of bytes have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| eccEnable | input | 1 | High: accumulate; low: clear and hold idle |
| blockSize | input | 3 | Block length select, 256 << value (values above 5 act as 5) |
| nandCeN | input | 1 | Active-low chip-enable of the monitored bank |
| nandWeN | input | 1 | Active-low write strobe |
| nandReN | input | 1 | Active-low read strobe |
| dataPhase | input | 1 | High during data transfers, low for command/address cycles |
| nandData | input | DATA_W | NAND data bus |
| eccCode | output | 32 | Accumulated parity code |
| eccValid | output | 1 | Block complete, code frozen |

## Verification
A wrong byte index or a miscounted strobe sends a byte into the wrong column-parity pair. This shows as a mismatch in bits 6 and up of eccCode once the block finishes. A skipped or doubled strobe moves the rise of eccValid away from the final byte by one transfer. That is visible three cycles after the strobe edge that should, or should not, have completed the block. A broken freeze or clear path shows within one cycle of the next strobe or of enable dropping, as a changed code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int MIN_LOG2  = 8;
  localparam int MAX_LOG2  = 13;
  localparam int NUM_SIZES = MAX_LOG2 - MIN_LOG2 + 1;
  localparam int CNT_W     = MAX_LOG2 + 1;
  localparam int ROW_BITS  = 6;
  localparam int ECC_W     = ROW_BITS + 2 * MAX_LOG2;

  // Strobes from control to datapath
  typedef struct packed {
    logic                clear;
    logic                accept;
    logic [MAX_LOG2-1:0] baseIdx;
    logic [MAX_LOG2-1:0] colMask;
  } ecc_ctrl_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [2:0]        sizeSel,
  input  logic              ceN,
  input  logic              weN,
  input  logic              reN,
  input  logic              phase,
  input  logic [DATA_W-1:0] dataIn,
  output ecc_ctrl_t         ctrlOut,
  output logic [DATA_W-1:0] dataAligned,
  output logic              valid
);
  localparam int LANES = DATA_W / 8;

  logic [2:0]        weSync, reSync;
  logic [1:0]        ceSync, phSync;
  logic [DATA_W-1:0] dataS1, dataS2;
  logic [CNT_W-1:0]  count, nextCount, blockLen;
  logic [2:0]        selC;
  logic              strobeEvt, accept;

  // Two-stage synchronisers plus one extra stage on strobes for edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weSync <= '1;
      reSync <= '1;
      ceSync <= '1;
      phSync <= '0;
      dataS1 <= '0;
      dataS2 <= '0;
    end else begin
      weSync <= {weSync[1:0], weN};
      reSync <= {reSync[1:0], reN};
      ceSync <= {ceSync[0], ceN};
      phSync <= {phSync[0], phase};
      dataS1 <= dataIn;
      dataS2 <= dataS1;
    end
  end

  assign strobeEvt = ((weSync[1] & ~weSync[2]) | (reSync[1] & ~reSync[2]))
                     & ~ceSync[1] & phSync[1];
  assign accept    = strobeEvt & enable & ~valid;
  assign nextCount = count + CNT_W'(LANES);

  always_comb begin
    selC     = (sizeSel > 3'(NUM_SIZES - 1)) ? 3'(NUM_SIZES - 1) : sizeSel;
    blockLen = CNT_W'(1) << (MIN_LOG2 + int'(selC));
    for (int k = 0; k < MAX_LOG2; k++)
      ctrlOut.colMask[k] = (k < MIN_LOG2 + int'(selC));
    ctrlOut.clear   = ~enable;
    ctrlOut.accept  = accept;
    ctrlOut.baseIdx = count[MAX_LOG2-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      valid <= 1'b0;
    end else if (!enable) begin
      count <= '0;
      valid <= 1'b0;
    end else if (accept) begin
      count <= nextCount;
      if (nextCount == blockLen) valid <= 1'b1;
    end
  end

  assign dataAligned = dataS2;
endmodule

// File: rtl/nand_ecc_dp.sv
module nand_ecc_dp
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ecc_ctrl_t         ctrlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ECC_W-1:0]  code
);
  localparam int LANES = DATA_W / 8;

  logic [ECC_W-1:0] delta;

  always_comb begin
    delta = '0;
    for (int l = 0; l < LANES; l++) begin : lane
      logic [7:0]          b;
      logic [MAX_LOG2-1:0] idx;
      logic                par;
      b   = dataIn[8*l +: 8];
      idx = ctrlIn.baseIdx + MAX_LOG2'(l);
      par = ^b;
      for (int j = 0; j < 8; j++)
        for (int r = 0; r < 3; r++)
          if (((j >> r) & 1) == 1) delta[2*r+1] = delta[2*r+1] ^ b[j];
          else                     delta[2*r]   = delta[2*r]   ^ b[j];
      for (int k = 0; k < MAX_LOG2; k++)
        if (ctrlIn.colMask[k]) begin
          if (idx[k]) delta[ROW_BITS+2*k+1] = delta[ROW_BITS+2*k+1] ^ par;
          else        delta[ROW_BITS+2*k]   = delta[ROW_BITS+2*k]   ^ par;
        end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              code <= '0;
    else if (ctrlIn.clear)  code <= '0;
    else if (ctrlIn.accept) code <= code ^ delta;
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEnable,
  input  logic [2:0]        blockSize,
  input  logic              nandCeN,
  input  logic              nandWeN,
  input  logic              nandReN,
  input  logic              dataPhase,
  input  logic [DATA_W-1:0] nandData,
  output logic [ECC_W-1:0]  eccCode,
  output logic              eccValid
);
  ecc_ctrl_t         ctrlStb;
  logic [DATA_W-1:0] dataAligned;
  logic              acceptStb;

  nand_ecc_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(eccEnable), .sizeSel(blockSize),
    .ceN(nandCeN), .weN(nandWeN), .reN(nandReN), .phase(dataPhase),
    .dataIn(nandData), .ctrlOut(ctrlStb), .dataAligned(dataAligned),
    .valid(eccValid)
  );

  nand_ecc_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlStb), .dataIn(dataAligned),
    .code(eccCode)
  );

  assign acceptStb = ctrlStb.accept;
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             eccEnable,
  input logic             eccValid,
  input logic [ECC_W-1:0] eccCode,
  input logic             acceptStb
);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !eccEnable |=> (eccCode == '0 && !eccValid));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eccValid && eccEnable) |=> eccValid);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eccValid && eccEnable) |=> $stable(eccCode));

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!acceptStb && eccEnable) |=> $stable(eccCode));

  p_valid_after_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eccValid) |-> $past(acceptStb));
endmodule

bind nand_ecc_acc nand_ecc_chk chk_i (
  .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .eccValid(eccValid),
  .eccCode(eccCode), .acceptStb(acceptStb)
);

// File: tb/nand_ecc_acc_tb.sv
module nand_ecc_acc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eccEnable = 1'b0;
  logic [2:0]  blockSize = 3'd0;
  logic        nandCeN = 1'b1, nandWeN = 1'b1, nandReN = 1'b1, dataPhase = 1'b0;
  logic [7:0]  nandData = 8'h00;
  logic [31:0] eccCode;
  logic        eccValid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nand_ecc_acc #(.DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .blockSize(blockSize),
    .nandCeN(nandCeN), .nandWeN(nandWeN), .nandReN(nandReN),
    .dataPhase(dataPhase), .nandData(nandData),
    .eccCode(eccCode), .eccValid(eccValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E3779B1 + 32'(seed) * 32'h7F4A7C15;
    h = h ^ (h >> 15);
    return h[7:0];
  endfunction

  // Reference code built from R2/R3 definitions
  function automatic logic [31:0] refEcc(input int seed, input int lg);
    logic [31:0] c = '0;
    for (int i = 0; i < (1 << lg); i++) begin
      logic [7:0] b = pat(seed, i);
      for (int j = 0; j < 8; j++)
        for (int r = 0; r < 3; r++)
          if (((j >> r) & 1) == 1) c[2*r+1] ^= b[j];
          else                     c[2*r]   ^= b[j];
      for (int k = 0; k < lg; k++)
        if (((i >> k) & 1) == 1) c[7+2*k] ^= ^b;
        else                     c[6+2*k] ^= ^b;
    end
    return c;
  endfunction

  task automatic pulse(input bit useRead, input bit ceLow, input bit ph, input logic [7:0] d);
    @(negedge clk);
    nandCeN = ~ceLow; dataPhase = ph; nandData = d;
    if (useRead) nandReN = 1'b0; else nandWeN = 1'b0;
    repeat (3) @(negedge clk);
    nandWeN = 1'b1; nandReN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 code", eccCode, 32'h0);
    check("R1 valid", {31'h0, eccValid}, 32'h1 - 32'h1);
  endtask

  task automatic run_block(input int seed, input int sel, input bit interleave);
    int len = 256 << sel;
    int lg = 8 + sel;
    logic [31:0] exp = refEcc(seed, lg);
    logic [31:0] held;
    @(negedge clk); blockSize = 3'(sel); eccEnable = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (interleave && (i % 17) == 3) begin
        pulse(1'b0, 1'b1, 1'b0, 8'hA5);  // R5 command/address cycle
        pulse(1'b1, 1'b0, 1'b1, 8'h3C);  // R5 other bank
      end
      if (i == len - 1) begin
        repeat (2) @(negedge clk);
        check("R9 valid low before last byte", {31'h0, eccValid}, 32'h0);
      end
      pulse(i[0], 1'b1, 1'b1, pat(seed, i));  // R4 reads and writes
    end
    repeat (3) @(negedge clk);
    check("R6 valid at block end", {31'h0, eccValid}, 32'h1);
    check(interleave ? "R5 code with interleaved cycles" : "R2 R3 code", eccCode, exp);
    if (lg < 13)
      check("R8 upper bits zero", eccCode >> (6 + 2 * lg), 32'h0);
    held = eccCode;
    pulse(1'b0, 1'b1, 1'b1, 8'hFF);
    pulse(1'b1, 1'b1, 1'b1, 8'h01);
    repeat (3) @(negedge clk);
    check("R6 frozen code", eccCode, held);
    check("R6 valid held", {31'h0, eccValid}, 32'h1);
    eccEnable = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 cleared code", eccCode, 32'h0);
    check("R7 cleared valid", {31'h0, eccValid}, 32'h0);
  endtask

  task automatic test_disabled_ignore();
    eccEnable = 1'b0;
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, 1'b1, 8'h5A + 8'(i));
    repeat (3) @(negedge clk);
    check("R7 strobes ignored while disabled", eccCode, 32'h0);
    check("R7 valid low while disabled", {31'h0, eccValid}, 32'h0);
    run_block(99, 0, 1'b0);  // R7 new block starts at index zero
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    run_block(7, 0, 1'b1);
    run_block(11, 1, 1'b1);
    for (int s = 0; s < 6; s++) run_block(20 + s, s, 1'b0);  // R3 every size
    test_disabled_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule